// File: doc/BRIEF.md
# Sensor Response Status Arbiter

This block decides which status a sensor returns each time a controller asks it for a sample over a serial link. After any reset it runs a two-phase warm-up. In the first phase it ignores all traffic. In the second phase register accesses work, but sample requests come back marked as having no data. It keeps a sticky flag that records that a reset happened, a bank of latched transient error flags, and a live critical-error input. From these it picks one 2-bit status code for every sample request.

The controller reaches the block through a small register port. A status register shows the reset flag, the warm-up busy bit and the transient flags. A control register has a write-one clear bit and a write-one restart bit; both are pulses and read back as zero. The warm-up length is a cycle-count parameter, and it grows by a second parameter while the high-pass select input is high. The first sample request after warm-up always returns no data. This lets a controller that polls slowly still see that the device restarted.

Top module: `sensor_status_reporter`

## Requirements
- R1: For PH1_CYC clock cycles after any reset, no register access is acknowledged and a sample request yields `resp_vld_o`=0 with code 00 (no response). Code encoding: 00 none, 01 no data, 10 error, 11 valid.
- R2: After that silent phase and until warm-up ends, register reads and writes are acknowledged one cycle later, status bit 1 (busy) reads 1, and a sample request returns code 01 unless a critical error is present.
- R3: Warm-up ends by itself INIT_CYC cycles after a reset with `hpf_sel_i` low, or INIT_CYC+HPF_EXTRA_CYC cycles with it high; status bit 1 then reads 0.
- R4: The first sample request after warm-up ends returns code 01 unless a critical error is present.
- R5: Status bit 0 (reset flag) is 1 after every reset. Writing 1 to control bit 0 (address 1) clears it only after warm-up has ended; such a write during warm-up leaves it at 1.
- R6: Power-on reset (`rst_n` low), a high `uv_evt_i` cycle, or writing 1 to control bit 1 outside the silent phase each restart warm-up from the silent phase, set the reset flag and clear all transient flags.
- R7: Transient flag i appears at status bit 2+i. It latches when `trans_i[i]` is high and clears on a control bit 0 write. If the condition is still present, the flag reads 0 once and is set again on the following cycle.
- R8: A sample request while `crit_i` is high, outside the silent phase, returns code 10 and overrides the no-data code.
- R9: After the first post-warm-up request, a request returns code 10 while the reset flag or any transient flag is set, and code 11 otherwise.
- R10: Reading the control register (address 1) returns 0.
- R11: `resp_vld_o` pulses one cycle after a request that is not in the silent phase. `resp_stat_o` changes only in the cycle after a request and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| uv_evt_i | input | 1 | Undervoltage event, restarts the block |
| hpf_sel_i | input | 1 | High-pass filter selected, lengthens warm-up |
| crit_i | input | 1 | Critical error condition present |
| trans_i | input | NUM_TRANS | Transient error conditions |
| req_i | input | 1 | Sample data request, one cycle |
| resp_vld_o | output | 1 | Response strobe |
| resp_stat_o | output | 2 | Response status code |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 status, 1 control |
| reg_wdata_i | input | 2 | Control write data: bit 0 clear, bit 1 restart |
| reg_ack_o | output | 1 | Register access acknowledge |
| reg_rdata_o | output | REG_DW | Register read data |

## Verification
The assertions check the following on every cycle: the response strobe and code timing, silence toward register traffic in the first phase, critical-error priority, no-data codes during warm-up and on the first post-warm-up request, zero control readback, and the return to the silent phase after an undervoltage event. Only the bench scenarios can show the rest. That includes the exact warm-up lengths with and without the high-pass select, the reset flag resisting a clear during warm-up, and a transient flag reading 0 once and coming back while its condition holds. It also covers the flag state under random mixes of pulses, clears and requests.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'b00,
        RSP_NODATA = 2'b01,
        RSP_ERROR  = 2'b10,
        RSP_VALID  = 2'b11
    } rsp_code_e;

    typedef enum logic [1:0] {
        PH_SILENT  = 2'b00,
        PH_WARMUP  = 2'b01,
        PH_FIRSTND = 2'b10,
        PH_RUN     = 2'b11
    } init_phase_e;

    localparam logic REG_STATUS = 1'b0;
    localparam logic REG_CTRL   = 1'b1;

    localparam int unsigned CTRL_W      = 2;
    localparam int unsigned CTRL_CLR    = 0;
    localparam int unsigned CTRL_SRST   = 1;
    localparam int unsigned STAT_DEVRES = 0;
    localparam int unsigned STAT_BUSY   = 1;
    localparam int unsigned STAT_TF_LSB = 2;

endpackage

// File: rtl/ssr_init_seq.sv
module ssr_init_seq
    import ssr_pkg::*;
#(
    parameter int unsigned PH1_CYC       = 16,
    parameter int unsigned INIT_CYC      = 64,
    parameter int unsigned HPF_EXTRA_CYC = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart_i,
    input  logic        hpf_sel_i,
    input  logic        req_i,
    output init_phase_e phase_o
);

    localparam int unsigned LONG_CYC = INIT_CYC + HPF_EXTRA_CYC;
    localparam int unsigned CW       = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] PH1_LAST   = CW'(PH1_CYC - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(INIT_CYC - 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);

    typedef struct packed {
        init_phase_e   phase;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        seq_d    = seq_q;
        last_cnt = hpf_sel_i ? LONG_LAST : SHORT_LAST;
        case (seq_q.phase)
            PH_SILENT: begin
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (seq_q.cnt == PH1_LAST) begin
                    seq_d.phase = PH_WARMUP;
                end
            end
            PH_WARMUP: begin
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (seq_q.cnt >= last_cnt) begin
                    seq_d.phase = PH_FIRSTND;
                    seq_d.cnt   = seq_q.cnt;
                end
            end
            PH_FIRSTND: begin
                if (req_i) begin
                    seq_d.phase = PH_RUN;
                end
            end
            default: begin
                seq_d = seq_q;
            end
        endcase
        if (restart_i) begin
            seq_d.phase = PH_SILENT;
            seq_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_SILENT, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;

endmodule

// File: rtl/ssr_flag_bank.sv
module ssr_flag_bank #(
    parameter int unsigned NUM_TRANS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart_i,
    input  logic                 clr_i,
    input  logic                 init_done_i,
    input  logic [NUM_TRANS-1:0] trans_i,
    output logic                 devres_o,
    output logic [NUM_TRANS-1:0] tflag_o
);

    typedef struct packed {
        logic                 devres;
        logic [NUM_TRANS-1:0] tflag;
    } flags_t;

    flags_t flg_d, flg_q;
    logic [NUM_TRANS-1:0] tflag_nxt;

    // One latch per transient condition; a clear wins for one cycle only
    for (genvar i = 0; i < NUM_TRANS; i++) begin : g_tflag
        assign tflag_nxt[i] = restart_i ? 1'b0
                            : clr_i     ? 1'b0
                            : (flg_q.tflag[i] | trans_i[i]);
    end

    always_comb begin
        flg_d       = flg_q;
        flg_d.tflag = tflag_nxt;
        if (restart_i) begin
            flg_d.devres = 1'b1;
        end else if (clr_i && init_done_i) begin
            flg_d.devres = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '{devres: 1'b1, tflag: '0};
        end else begin
            flg_q <= flg_d;
        end
    end

    assign devres_o = flg_q.devres;
    assign tflag_o  = flg_q.tflag;

endmodule

// File: rtl/ssr_reg_if.sv
module ssr_reg_if
    import ssr_pkg::*;
#(
    parameter int unsigned NUM_TRANS = 4,
    parameter int unsigned REG_DW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  init_phase_e          phase_i,
    input  logic                 reg_rd_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_addr_i,
    input  logic [CTRL_W-1:0]    reg_wdata_i,
    input  logic                 devres_i,
    input  logic [NUM_TRANS-1:0] tflag_i,
    output logic                 clr_pulse_o,
    output logic                 srst_pulse_o,
    output logic                 reg_ack_o,
    output logic [REG_DW-1:0]    reg_rdata_o
);

    typedef struct packed {
        logic              ack;
        logic [REG_DW-1:0] rdata;
    } rif_t;

    rif_t rif_d, rif_q;
    logic              access_ok;
    logic              ctrl_wr;
    logic [REG_DW-1:0] stat_word;

    always_comb begin
        access_ok    = (phase_i != PH_SILENT);
        ctrl_wr      = reg_wr_i && access_ok && (reg_addr_i == REG_CTRL);
        clr_pulse_o  = ctrl_wr && reg_wdata_i[CTRL_CLR];
        srst_pulse_o = ctrl_wr && reg_wdata_i[CTRL_SRST];

        stat_word                           = '0;
        stat_word[STAT_DEVRES]              = devres_i;
        stat_word[STAT_BUSY]                = (phase_i == PH_WARMUP);
        stat_word[STAT_TF_LSB +: NUM_TRANS] = tflag_i;

        rif_d.ack   = access_ok && (reg_rd_i || reg_wr_i);
        rif_d.rdata = '0;
        if (access_ok && reg_rd_i && (reg_addr_i == REG_STATUS)) begin
            rif_d.rdata = stat_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rif_q <= '{ack: 1'b0, rdata: '0};
        end else begin
            rif_q <= rif_d;
        end
    end

    assign reg_ack_o   = rif_q.ack;
    assign reg_rdata_o = rif_q.rdata;

endmodule

// File: rtl/ssr_resp_arb.sv
module ssr_resp_arb
    import ssr_pkg::*;
#(
    parameter int unsigned NUM_TRANS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 crit_i,
    input  init_phase_e          phase_i,
    input  logic                 devres_i,
    input  logic [NUM_TRANS-1:0] tflag_i,
    output logic                 resp_vld_o,
    output rsp_code_e            resp_stat_o
);

    typedef struct packed {
        logic      vld;
        rsp_code_e stat;
    } arb_t;

    arb_t      arb_d, arb_q;
    rsp_code_e code;

    // Priority: silence, critical, warm-up no-data, flagged error, valid
    always_comb begin
        if (phase_i == PH_SILENT) begin
            code = RSP_NONE;
        end else if (crit_i) begin
            code = RSP_ERROR;
        end else if ((phase_i == PH_WARMUP) || (phase_i == PH_FIRSTND)) begin
            code = RSP_NODATA;
        end else if (devres_i || (|tflag_i)) begin
            code = RSP_ERROR;
        end else begin
            code = RSP_VALID;
        end

        arb_d     = arb_q;
        arb_d.vld = req_i && (code != RSP_NONE);
        if (req_i) begin
            arb_d.stat = code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q <= '{vld: 1'b0, stat: RSP_NONE};
        end else begin
            arb_q <= arb_d;
        end
    end

    assign resp_vld_o  = arb_q.vld;
    assign resp_stat_o = arb_q.stat;

endmodule

// File: rtl/sensor_status_reporter.sv
module sensor_status_reporter
    import ssr_pkg::*;
#(
    parameter int unsigned PH1_CYC       = 16,
    parameter int unsigned INIT_CYC      = 64,
    parameter int unsigned HPF_EXTRA_CYC = 128,
    parameter int unsigned NUM_TRANS     = 4,
    parameter int unsigned REG_DW        = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 uv_evt_i,
    input  logic                 hpf_sel_i,
    input  logic                 crit_i,
    input  logic [NUM_TRANS-1:0] trans_i,
    input  logic                 req_i,
    output logic                 resp_vld_o,
    output logic [1:0]           resp_stat_o,
    input  logic                 reg_rd_i,
    input  logic                 reg_wr_i,
    input  logic                 reg_addr_i,
    input  logic [1:0]           reg_wdata_i,
    output logic                 reg_ack_o,
    output logic [REG_DW-1:0]    reg_rdata_o
);

    init_phase_e          phase;
    logic                 restart;
    logic                 clr_pulse;
    logic                 srst_pulse;
    logic                 init_done;
    logic                 devres;
    logic [NUM_TRANS-1:0] tflag;
    rsp_code_e            stat_code;

    assign restart   = uv_evt_i || srst_pulse;
    assign init_done = (phase == PH_FIRSTND) || (phase == PH_RUN);

    ssr_init_seq #(
        .PH1_CYC      (PH1_CYC),
        .INIT_CYC     (INIT_CYC),
        .HPF_EXTRA_CYC(HPF_EXTRA_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(restart),
        .hpf_sel_i(hpf_sel_i),
        .req_i    (req_i),
        .phase_o  (phase)
    );

    ssr_flag_bank #(
        .NUM_TRANS(NUM_TRANS)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .clr_i      (clr_pulse),
        .init_done_i(init_done),
        .trans_i    (trans_i),
        .devres_o   (devres),
        .tflag_o    (tflag)
    );

    ssr_reg_if #(
        .NUM_TRANS(NUM_TRANS),
        .REG_DW   (REG_DW)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase),
        .reg_rd_i    (reg_rd_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .devres_i    (devres),
        .tflag_i     (tflag),
        .clr_pulse_o (clr_pulse),
        .srst_pulse_o(srst_pulse),
        .reg_ack_o   (reg_ack_o),
        .reg_rdata_o (reg_rdata_o)
    );

    ssr_resp_arb #(
        .NUM_TRANS(NUM_TRANS)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .crit_i     (crit_i),
        .phase_i    (phase),
        .devres_i   (devres),
        .tflag_i    (tflag),
        .resp_vld_o (resp_vld_o),
        .resp_stat_o(stat_code)
    );

    assign resp_stat_o = stat_code;

endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
    import ssr_pkg::*;
#(
    parameter int unsigned REG_DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              crit_i,
    input logic              uv_evt_i,
    input logic              reg_rd_i,
    input logic              reg_wr_i,
    input logic              reg_addr_i,
    input logic              resp_vld_o,
    input logic [1:0]        resp_stat_o,
    input logic              reg_ack_o,
    input logic [REG_DW-1:0] reg_rdata_o,
    input init_phase_e       phase
);

    assert_silent_no_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SILENT && (reg_rd_i || reg_wr_i)) |=> !reg_ack_o);

    assert_silent_no_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SILENT && req_i) |=> (!resp_vld_o && resp_stat_o == RSP_NONE));

    assert_warmup_nodata_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !crit_i && phase == PH_WARMUP) |=> (resp_stat_o == RSP_NODATA));

    assert_first_nodata_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !crit_i && phase == PH_FIRSTND) |=> (resp_stat_o == RSP_NODATA));

    assert_uv_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uv_evt_i |=> (phase == PH_SILENT));

    assert_crit_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && crit_i && phase != PH_SILENT) |=> (resp_stat_o == RSP_ERROR));

    assert_run_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && phase == PH_RUN) |=> (resp_stat_o == RSP_ERROR || resp_stat_o == RSP_VALID));

    assert_ctrl_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_i && reg_addr_i == REG_CTRL && phase != PH_SILENT)
            |=> (reg_ack_o && reg_rdata_o == '0));

    assert_vld_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld_o |-> ($past(req_i) && resp_stat_o != RSP_NONE));

    assert_stat_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(resp_stat_o));

endmodule

bind sensor_status_reporter ssr_checker #(
    .REG_DW(REG_DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .crit_i     (crit_i),
    .uv_evt_i   (uv_evt_i),
    .reg_rd_i   (reg_rd_i),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .resp_vld_o (resp_vld_o),
    .resp_stat_o(resp_stat_o),
    .reg_ack_o  (reg_ack_o),
    .reg_rdata_o(reg_rdata_o),
    .phase      (phase)
);

// File: tb/tb_sensor_status_reporter.sv
module tb_sensor_status_reporter;

    localparam int PH1  = 16;
    localparam int INIT = 64;
    localparam int HPFX = 128;
    localparam int NT   = 4;
    localparam int DW   = 8;

    localparam logic [1:0] C_NONE = 2'b00, C_ND = 2'b01, C_ERR = 2'b10, C_VAL = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          uv_evt_i = 1'b0;
    logic          hpf_sel_i = 1'b0;
    logic          crit_i = 1'b0;
    logic [NT-1:0] trans_i = '0;
    logic          req_i = 1'b0;
    logic          resp_vld_o;
    logic [1:0]    resp_stat_o;
    logic          reg_rd_i = 1'b0;
    logic          reg_wr_i = 1'b0;
    logic          reg_addr_i = 1'b0;
    logic [1:0]    reg_wdata_i = '0;
    logic          reg_ack_o;
    logic [DW-1:0] reg_rdata_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int base    = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    sensor_status_reporter #(
        .PH1_CYC(PH1), .INIT_CYC(INIT), .HPF_EXTRA_CYC(HPFX),
        .NUM_TRANS(NT), .REG_DW(DW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .uv_evt_i(uv_evt_i), .hpf_sel_i(hpf_sel_i),
        .crit_i(crit_i), .trans_i(trans_i), .req_i(req_i),
        .resp_vld_o(resp_vld_o), .resp_stat_o(resp_stat_o),
        .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_ack_o(reg_ack_o), .reg_rdata_o(reg_rdata_o)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    function automatic logic [DW-1:0] stat_word(input logic dev, input logic busy,
                                                input logic [NT-1:0] tf);
        logic [DW-1:0] w;
        w = '0;
        w[0] = dev;
        w[1] = busy;
        w[2 +: NT] = tf;
        return w;
    endfunction

    function automatic logic [1:0] exp_code(input logic crit, input logic first_nd,
                                            input logic dev, input logic [NT-1:0] tf);
        if (crit)                  return C_ERR;
        else if (first_nd)         return C_ND;
        else if (dev || (|tf))     return C_ERR;
        else                       return C_VAL;
    endfunction

    // All tasks start and end at a falling edge
    task automatic do_req(input logic crit, output logic vld, output logic [1:0] st);
        req_i = 1'b1; crit_i = crit;
        @(negedge clk);
        req_i = 1'b0; crit_i = 1'b0;
        vld = resp_vld_o; st = resp_stat_o;
    endtask

    task automatic do_read(input logic addr, output logic ack, output logic [DW-1:0] d);
        reg_rd_i = 1'b1; reg_addr_i = addr;
        @(negedge clk);
        reg_rd_i = 1'b0; reg_addr_i = 1'b0;
        ack = reg_ack_o; d = reg_rdata_o;
    endtask

    task automatic do_write(input logic [1:0] w);
        reg_wr_i = 1'b1; reg_addr_i = 1'b1; reg_wdata_i = w;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_addr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic pulse_trans(input logic [NT-1:0] v);
        trans_i = v;
        @(negedge clk);
        trans_i = '0;
    endtask

    task automatic wait_rel(input int n);
        while (cyc - base < n) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic v, ack;
        logic [1:0] st;
        logic [DW-1:0] d;
        logic dev, first_nd;
        logic [NT-1:0] tf;
        void'($urandom(32'h5eed_1234));

        repeat (3) @(negedge clk);
        check("reset R11 vld", int'(resp_vld_o), 0);
        check("reset R1 code", int'(resp_stat_o), int'(C_NONE));
        check("reset R1 ack", int'(reg_ack_o), 0);
        rst_n = 1'b1;
        base = 0;

        // Silent phase boundary
        wait_rel(PH1 - 1);
        do_read(1'b0, ack, d);
        check("R1 no ack at last silent cycle", int'(ack), 0);
        do_read(1'b0, ack, d);
        check("R2 ack at first warm-up cycle", int'(ack), 1);
        check("R2 R5 status in warm-up", int'(d), int'(stat_word(1, 1, '0)));
        do_req(1'b0, v, st);
        check("R2 warm-up request code", int'(st), int'(C_ND));
        check("R11 vld in warm-up", int'(v), 1);
        do_req(1'b1, v, st);
        check("R8 critical overrides no-data", int'(st), int'(C_ERR));
        do_write(2'b01);
        do_read(1'b0, ack, d);
        check("R5 clear ignored during warm-up", int'(d), int'(stat_word(1, 1, '0)));
        do_read(1'b1, ack, d);
        check("R10 control reads zero", int'(d), 0);

        // End of warm-up boundary
        wait_rel(INIT - 1);
        do_read(1'b0, ack, d);
        check("R3 busy at last warm-up cycle", int'(d), int'(stat_word(1, 1, '0)));
        do_read(1'b0, ack, d);
        check("R3 busy clears after INIT_CYC", int'(d), int'(stat_word(1, 0, '0)));
        do_req(1'b0, v, st);
        check("R4 first request no-data", int'(st), int'(C_ND));
        do_req(1'b0, v, st);
        check("R9 reset flag reports error", int'(st), int'(C_ERR));
        do_write(2'b01);
        do_read(1'b0, ack, d);
        check("R5 clear after warm-up", int'(d), 0);
        do_req(1'b0, v, st);
        check("R9 clean request valid", int'(st), int'(C_VAL));
        do_req(1'b1, v, st);
        check("R8 critical in run", int'(st), int'(C_ERR));

        // Transient flags
        pulse_trans(4'b0010);
        do_read(1'b0, ack, d);
        check("R7 flag latched at bit 3", int'(d), int'(stat_word(0, 0, 4'b0010)));
        do_req(1'b0, v, st);
        check("R9 transient reports error", int'(st), int'(C_ERR));
        trans_i = 4'b0001;
        do_write(2'b01);
        do_read(1'b0, ack, d);
        check("R7 flag momentarily cleared", int'(d), 0);
        do_read(1'b0, ack, d);
        check("R7 flag set again while present", int'(d), int'(stat_word(0, 0, 4'b0001)));
        trans_i = '0;
        do_write(2'b01);
        do_read(1'b0, ack, d);
        check("R7 flag cleared when gone", int'(d), 0);

        // Command restart with long warm-up
        pulse_trans(4'b1000);
        hpf_sel_i = 1'b1;
        do_write(2'b10);
        base = cyc;
        do_read(1'b0, ack, d);
        check("R6 command restart silent", int'(ack), 0);
        wait_rel(INIT);
        do_read(1'b0, ack, d);
        check("R3 R6 still busy with filter", int'(d), int'(stat_word(1, 1, '0)));
        wait_rel(INIT + HPFX - 1);
        do_read(1'b0, ack, d);
        check("R3 busy at last long cycle", int'(d), int'(stat_word(1, 1, '0)));
        do_read(1'b0, ack, d);
        check("R3 long warm-up ends", int'(d), int'(stat_word(1, 0, '0)));

        // Undervoltage restart
        do_req(1'b0, v, st);
        uv_evt_i = 1'b1;
        @(negedge clk);
        uv_evt_i = 1'b0;
        base = cyc;
        hpf_sel_i = 1'b0;
        do_req(1'b0, v, st);
        check("R6 R1 undervoltage silences response", int'(v), 0);
        check("R1 silent code", int'(st), int'(C_NONE));
        wait_rel(INIT);
        do_read(1'b0, ack, d);
        check("R6 reset flag set after undervoltage", int'(d), int'(stat_word(1, 0, '0)));
        do_req(1'b0, v, st);
        check("R4 first request after undervoltage", int'(st), int'(C_ND));
        do_write(2'b01);

        // Random mix against a bench model
        dev = 1'b0; tf = '0; first_nd = 1'b0;
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom % 4;
            case (op)
                0: begin
                    logic [NT-1:0] pv;
                    pv = NT'($urandom);
                    pulse_trans(pv);
                    tf = tf | pv;
                end
                1: begin
                    logic c;
                    c = (($urandom % 4) == 0);
                    do_req(c, v, st);
                    check("R9 R8 random request code", int'(st), int'(exp_code(c, first_nd, dev, tf)));
                    check("R11 random vld", int'(v), 1);
                end
                2: begin
                    do_write(2'b01);
                    dev = 1'b0; tf = '0;
                end
                default: begin
                    do_read(1'b0, ack, d);
                    check("R7 R5 random status", int'(d), int'(stat_word(dev, 0, tf)));
                end
            endcase
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule